// File: doc/BRIEF.md
# Multiple-Writer Directory Entry Controller

This block is the home-node logic that keeps the directory entry of one cache block under a lazy release-consistent coherence protocol. Up to `NODES` nodes send it four kinds of request: read, write, drop (the node invalidated or evicted its copy) and acknowledge (the node has seen a write notice). The entry holds a block state, one sharer bit, one writer bit and one notified bit per node, the set of nodes whose acknowledgement is still owed, the set of writers waiting for that collection, and counts of sharers and writers.

Reads and writes from a node that does not hold the block are always served from memory through a request/acknowledge handshake and are never forwarded to another node. Writes do not serialise on a single owner. Several nodes may write at once, which puts the block in the Weak state. Every sharer not yet told about the Weak episode gets one write notice. One acknowledgement collection serves every writer that arrives while it is open, and all of them are released together when the last owed acknowledgement comes in.

The controller has two FSM states. FS_IDLE accepts a request. It applies drops, acknowledgements and writes from holders in that cycle. Reads and writes from non-holders take the FS_IDLE to FS_FETCH transition. FS_FETCH holds `mem_req` until `mem_ack`, then applies the latched request and returns to FS_IDLE. All replies, notices and releases are registered one-cycle pulses that appear the cycle after the request is applied.

Top module: `mwdir_ctrl`

## Requirements
- R1: After reset the block state is Uncached (code 0), all per-node vectors and both counts are zero, `req_ready` is high and no pulse output is active.
- R2: A read, or a write from a node whose sharer bit is clear, raises `mem_req` and drops `req_ready` in the cycle after acceptance. Both stay that way until `mem_ack`. The cycle after `mem_ack` brings the reply to that node; for a read the reply kind is DATA (code 0).
- R3: After every applied request the state code is derived from the vectors. It is 0 Uncached when there are no sharers and 1 Shared when there are sharers but no writers. It is 2 Dirty when exactly one node shares and writes, and 3 Weak in every other case. `share_cnt` and `write_cnt` equal the number of set bits.
- R4: A read from a new node of a Dirty block moves it to Weak and sends a write notice to the writer only. No acknowledgement is collected for that notice.
- R5: A write to an Uncached block, or to a block held only by the requester, gets reply GO (code 1). A write from a node that already holds the block gets its reply the cycle after the request, without a memory fetch.
- R6: A write that leaves the block Weak sends write notices (`notice_vec`, bit per node) to every other sharer whose notified bit is clear. Those nodes are added to the owed set. The requester gets WAIT (code 2) whenever the owed set is then non-empty.
- R7: A sharer already notified in the current Weak episode gets no second notice. A write into Weak that finds nothing owed and no new node to notify gets GO.
- R8: When the owed set becomes empty, `done_vec` pulses once with every waiting writer and the waiting set clears. An acknowledgement from a node that is not owed changes nothing.
- R9: A drop clears the node's sharer, writer and notified bits. A drop from an owed node counts as its acknowledgement.
- R10: Leaving the Weak state clears all notified bits and the owed set, which releases any waiting writers. A later Weak episode notifies nodes afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request (FS_IDLE) |
| req_kind | input | 2 | 0 read, 1 write, 2 drop, 3 acknowledge |
| req_node | input | IW | Requesting node |
| mem_req | output | 1 | Memory read of the block outstanding |
| mem_ack | input | 1 | Memory returned the block |
| rep_valid | output | 1 | Reply pulse to a requester |
| rep_kind | output | 2 | 0 DATA, 1 GO, 2 WAIT |
| rep_node | output | IW | Node the reply goes to |
| notice_vec | output | NODES | Write notices sent this cycle, bit per node |
| done_vec | output | NODES | Collected acknowledgement released to these writers |
| blk_state | output | 2 | Directory state code |
| share_vec | output | NODES | Sharer bits |
| write_vec | output | NODES | Writer bits |
| share_cnt | output | CW | Number of sharers |
| write_cnt | output | CW | Number of writers |

## Verification
The bench targets four corner cases:
- A Dirty-to-Weak read: a design that notified the reader or collected acks for it would show a stray `notice_vec` bit.
- A second writer arriving while a collection is open: a wrong design would either re-notify sharers or release the first writer early.
- An eviction from the last owed node: without counting it as an ack, the writers would hang with `done_vec` never pulsing.
- A block that drops out of Weak and re-enters it: stale notified bits would suppress the fresh notice to the old writer.

Random sequences from all nodes are compared every step against a bench model of the requirements.

// File: rtl/mwdir_pkg.sv
package mwdir_pkg;
    typedef enum logic [1:0] {
        BLK_UNC  = 2'd0,
        BLK_SHR  = 2'd1,
        BLK_DRT  = 2'd2,
        BLK_WEAK = 2'd3
    } blk_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_DROP  = 2'd2,
        OP_ACK   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RP_DATA = 2'd0,
        RP_GO   = 2'd1,
        RP_WAIT = 2'd2
    } rep_e;

    typedef enum logic {
        FS_IDLE  = 1'b0,
        FS_FETCH = 1'b1
    } fsm_e;
endpackage

// File: rtl/mwdir_popcnt.sv
module mwdir_popcnt #(
    parameter int W  = 4,
    parameter int CW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] part [0:W];

    assign part[0] = '0;
    for (genvar g = 0; g < W; g++) begin : g_sum
        assign part[g+1] = part[g] + CW'(vec[g]);
    end
    assign cnt = part[W];
endmodule

// File: rtl/mwdir_update.sv
module mwdir_update
    import mwdir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int IW    = 2,
    parameter int CW    = 3
) (
    input  op_e              op,
    input  logic [IW-1:0]    node,
    input  logic [NODES-1:0] sh_i,
    input  logic [NODES-1:0] wr_i,
    input  logic [NODES-1:0] nt_i,
    input  logic [NODES-1:0] pd_i,
    input  logic [NODES-1:0] wt_i,
    output logic [NODES-1:0] sh_o,
    output logic [NODES-1:0] wr_o,
    output logic [NODES-1:0] nt_o,
    output logic [NODES-1:0] pd_o,
    output logic [NODES-1:0] wt_o,
    output blk_e             st_o,
    output logic [CW-1:0]    cs_o,
    output logic [CW-1:0]    cw_o,
    output rep_e             rep_o,
    output logic [NODES-1:0] notice_o,
    output logic [NODES-1:0] done_o
);
    logic [NODES-1:0] oh;
    logic [NODES-1:0] pd_m;
    logic [NODES-1:0] wt_m;

    // membership change of the requester
    always_comb begin
        oh       = '0;
        oh[node] = 1'b1;
        sh_o     = sh_i;
        wr_o     = wr_i;
        unique case (op)
            OP_READ:  sh_o = sh_i | oh;
            OP_WRITE: begin
                sh_o = sh_i | oh;
                wr_o = wr_i | oh;
            end
            OP_DROP:  begin
                sh_o = sh_i & ~oh;
                wr_o = wr_i & ~oh;
            end
            OP_ACK:   ;
        endcase
    end

    mwdir_popcnt #(.W(NODES), .CW(CW)) u_cnt_sh (.vec(sh_o), .cnt(cs_o));
    mwdir_popcnt #(.W(NODES), .CW(CW)) u_cnt_wr (.vec(wr_o), .cnt(cw_o));

    // block state follows the vectors
    always_comb begin
        if (cs_o == '0)
            st_o = BLK_UNC;
        else if (cw_o == '0)
            st_o = BLK_SHR;
        else if (cs_o == CW'(1))
            st_o = BLK_DRT;
        else
            st_o = BLK_WEAK;
    end

    // notices, acknowledgement collection and release
    always_comb begin
        nt_o     = nt_i;
        pd_m     = pd_i;
        wt_m     = wt_i;
        notice_o = '0;
        rep_o    = RP_DATA;
        done_o   = '0;
        unique case (op)
            OP_READ: begin
                if (st_o == BLK_WEAK) begin
                    notice_o = wr_o & ~nt_i & ~oh;
                    nt_o     = nt_i | notice_o | oh;
                end
            end
            OP_WRITE: begin
                rep_o = RP_GO;
                if (st_o == BLK_WEAK) begin
                    notice_o = sh_o & ~oh & ~nt_i;
                    nt_o     = nt_i | notice_o | oh;
                    pd_m     = pd_i | notice_o;
                    if (pd_m != '0) begin
                        wt_m  = wt_i | oh;
                        rep_o = RP_WAIT;
                    end
                end
            end
            OP_DROP: begin
                nt_o = nt_i & ~oh;
                pd_m = pd_i & ~oh;
            end
            OP_ACK: pd_m = pd_i & ~oh;
        endcase
        if (st_o != BLK_WEAK) begin
            nt_o = '0;
            pd_m = '0;
        end
        if (pd_m == '0 && wt_m != '0) begin
            done_o = wt_m;
            wt_m   = '0;
        end
    end

    assign pd_o = pd_m;
    assign wt_o = wt_m;
endmodule

// File: rtl/mwdir_ctrl.sv
module mwdir_ctrl
    import mwdir_pkg::*;
#(
    parameter int NODES = 4,
    parameter int IW    = (NODES > 1) ? $clog2(NODES) : 1,
    parameter int CW    = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [IW-1:0]    req_node,
    output logic             mem_req,
    input  logic             mem_ack,
    output logic             rep_valid,
    output logic [1:0]       rep_kind,
    output logic [IW-1:0]    rep_node,
    output logic [NODES-1:0] notice_vec,
    output logic [NODES-1:0] done_vec,
    output logic [1:0]       blk_state,
    output logic [NODES-1:0] share_vec,
    output logic [NODES-1:0] write_vec,
    output logic [CW-1:0]    share_cnt,
    output logic [CW-1:0]    write_cnt
);
    fsm_e             fsm;
    op_e              lat_op;
    logic [IW-1:0]    lat_node;

    blk_e             st;
    logic [NODES-1:0] sh, wr, nt, pd, wt;
    logic [CW-1:0]    cs, cw;

    op_e              live_op;
    op_e              sel_op;
    logic [IW-1:0]    sel_node;
    logic             live_fetch;
    logic             apply;

    logic [NODES-1:0] sh_n, wr_n, nt_n, pd_n, wt_n, notice_n, done_n;
    blk_e             st_n;
    logic [CW-1:0]    cs_n, cw_n;
    rep_e             rep_n;

    assign live_op    = op_e'(req_kind);
    assign live_fetch = (live_op == OP_READ) ||
                        (live_op == OP_WRITE && !sh[req_node]);
    assign sel_op     = (fsm == FS_FETCH) ? lat_op : live_op;
    assign sel_node   = (fsm == FS_FETCH) ? lat_node : req_node;
    assign apply      = (fsm == FS_IDLE && req_valid && !live_fetch) ||
                        (fsm == FS_FETCH && mem_ack);

    assign req_ready  = (fsm == FS_IDLE);
    assign mem_req    = (fsm == FS_FETCH);

    mwdir_update #(.NODES(NODES), .IW(IW), .CW(CW)) u_upd (
        .op(sel_op), .node(sel_node),
        .sh_i(sh), .wr_i(wr), .nt_i(nt), .pd_i(pd), .wt_i(wt),
        .sh_o(sh_n), .wr_o(wr_n), .nt_o(nt_n), .pd_o(pd_n), .wt_o(wt_n),
        .st_o(st_n), .cs_o(cs_n), .cw_o(cw_n), .rep_o(rep_n),
        .notice_o(notice_n), .done_o(done_n)
    );

    // state register: fetch sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm      <= FS_IDLE;
            lat_op   <= OP_READ;
            lat_node <= '0;
        end else begin
            unique case (fsm)
                FS_IDLE: begin
                    if (req_valid && live_fetch) begin
                        fsm      <= FS_FETCH;
                        lat_op   <= live_op;
                        lat_node <= req_node;
                    end
                end
                FS_FETCH: begin
                    if (mem_ack)
                        fsm <= FS_IDLE;
                end
            endcase
        end
    end

    // outputs and directory entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= BLK_UNC;
            sh         <= '0;
            wr         <= '0;
            nt         <= '0;
            pd         <= '0;
            wt         <= '0;
            cs         <= '0;
            cw         <= '0;
            rep_valid  <= 1'b0;
            rep_kind   <= RP_DATA;
            rep_node   <= '0;
            notice_vec <= '0;
            done_vec   <= '0;
        end else begin
            rep_valid  <= 1'b0;
            notice_vec <= '0;
            done_vec   <= '0;
            if (apply) begin
                st         <= st_n;
                sh         <= sh_n;
                wr         <= wr_n;
                nt         <= nt_n;
                pd         <= pd_n;
                wt         <= wt_n;
                cs         <= cs_n;
                cw         <= cw_n;
                rep_valid  <= (sel_op == OP_READ) || (sel_op == OP_WRITE);
                rep_kind   <= rep_n;
                rep_node   <= sel_node;
                notice_vec <= notice_n;
                done_vec   <= done_n;
            end
        end
    end

    assign blk_state = st;
    assign share_vec = sh;
    assign write_vec = wr;
    assign share_cnt = cs;
    assign write_cnt = cw;
endmodule

// File: rtl/mwdir_chk.sv
module mwdir_chk #(
    parameter int NODES = 4,
    parameter int IW    = 2,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [NODES-1:0] notice_vec,
    input logic [1:0]       blk_state,
    input logic [NODES-1:0] share_vec,
    input logic [NODES-1:0] write_vec,
    input logic [CW-1:0]    share_cnt,
    input logic [CW-1:0]    write_cnt
);
    p_unc_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        blk_state == 2'd0 |-> share_vec == '0 && write_vec == '0);

    p_fetch_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    p_dirty_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_state == 2'd2 |-> share_cnt == CW'(1) && write_cnt == CW'(1));

    p_weak_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_state == 2'd3 |-> share_cnt >= CW'(2) && write_cnt >= CW'(1));

    p_writer_shares_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (write_vec & ~share_vec) == '0);

    p_count_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        share_cnt == CW'($countones(share_vec)));

    p_notice_sharer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (notice_vec & ~share_vec) == '0);
endmodule

bind mwdir_ctrl mwdir_chk #(.NODES(NODES), .IW(IW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
    .mem_ack(mem_ack), .notice_vec(notice_vec), .blk_state(blk_state),
    .share_vec(share_vec), .write_vec(write_vec),
    .share_cnt(share_cnt), .write_cnt(write_cnt)
);

// File: tb/tb_mwdir_ctrl.sv
module tb_mwdir_ctrl;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = 2'd0;
    logic [IW-1:0] req_node = '0;
    logic          mem_req;
    logic          mem_ack = 1'b0;
    logic          rep_valid;
    logic [1:0]    rep_kind;
    logic [IW-1:0] rep_node;
    logic [N-1:0]  notice_vec, done_vec, share_vec, write_vec;
    logic [1:0]    blk_state;
    logic [CW-1:0] share_cnt, write_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_sh = '0, m_wr = '0, m_nt = '0, m_pd = '0, m_wt = '0;
    int           m_st = 0;

    always #5 clk = ~clk;

    mwdir_ctrl #(.NODES(N)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_node(req_node), .mem_req(mem_req),
        .mem_ack(mem_ack), .rep_valid(rep_valid), .rep_kind(rep_kind),
        .rep_node(rep_node), .notice_vec(notice_vec), .done_vec(done_vec),
        .blk_state(blk_state), .share_vec(share_vec), .write_vec(write_vec),
        .share_cnt(share_cnt), .write_cnt(write_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    // reference model built from the requirements
    task automatic model(input int kind, input int node, output bit ev,
                         output int ek, output logic [N-1:0] enot,
                         output logic [N-1:0] edone);
        logic [N-1:0] sh = m_sh, wr = m_wr, nt = m_nt, pd = m_pd, wt = m_wt;
        int ns;
        if (kind == 0) sh[node] = 1'b1;
        if (kind == 1) begin sh[node] = 1'b1; wr[node] = 1'b1; end
        if (kind == 2) begin sh[node] = 1'b0; wr[node] = 1'b0; end
        if (ones(sh) == 0)      ns = 0;
        else if (ones(wr) == 0) ns = 1;
        else if (ones(sh) == 1) ns = 2;
        else                    ns = 3;
        ev = (kind < 2);
        ek = (kind == 1) ? 1 : 0;
        enot = '0;
        edone = '0;
        if (ns == 3 && kind == 0) begin
            for (int i = 0; i < N; i++)
                if (wr[i] && !nt[i] && i != node) enot[i] = 1'b1;
            nt = nt | enot;
            nt[node] = 1'b1;
        end
        if (ns == 3 && kind == 1) begin
            for (int i = 0; i < N; i++)
                if (sh[i] && !nt[i] && i != node) enot[i] = 1'b1;
            nt = nt | enot;
            nt[node] = 1'b1;
            pd = pd | enot;
            if (pd != '0) begin wt[node] = 1'b1; ek = 2; end
        end
        if (kind == 2) begin nt[node] = 1'b0; pd[node] = 1'b0; end
        if (kind == 3) pd[node] = 1'b0;
        if (ns != 3) begin nt = '0; pd = '0; end
        if (pd == '0 && wt != '0) begin edone = wt; wt = '0; end
        m_sh = sh; m_wr = wr; m_nt = nt; m_pd = pd; m_wt = wt; m_st = ns;
    endtask

    task automatic do_op(input int kind, input int node, input string tag);
        bit fetch;
        bit ev;
        int ek;
        logic [N-1:0] enot, edone;
        fetch = (kind == 0) || (kind == 1 && !m_sh[node]);
        model(kind, node, ev, ek, enot, edone);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_node  = IW'(node);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (fetch) begin
            chk({tag, " R2 fetch mem_req"}, int'(mem_req), 1);
            chk({tag, " R2 fetch ready low"}, int'(req_ready), 0);
            repeat ($urandom % 3) @(negedge clk);
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
        end
        chk({tag, " rep_valid"}, int'(rep_valid), int'(ev));
        if (ev) begin
            chk({tag, " rep_kind"}, int'(rep_kind), ek);
            chk({tag, " rep_node"}, int'(rep_node), node);
        end
        chk({tag, " notice_vec"}, int'(notice_vec), int'(enot));
        chk({tag, " done_vec"}, int'(done_vec), int'(edone));
        chk({tag, " R3 state"}, int'(blk_state), m_st);
        chk({tag, " share_vec"}, int'(share_vec), int'(m_sh));
        chk({tag, " write_vec"}, int'(write_vec), int'(m_wr));
        chk({tag, " R3 share_cnt"}, int'(share_cnt), ones(m_sh));
        chk({tag, " R3 write_cnt"}, int'(write_cnt), ones(m_wr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(blk_state), 0);
        chk("R1 share", int'(share_vec), 0);
        chk("R1 write", int'(write_vec), 0);
        chk("R1 counts", int'(share_cnt) + int'(write_cnt), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 pulses", int'(rep_valid) + int'(notice_vec) + int'(done_vec), 0);

        // directed: Dirty then read makes Weak
        do_op(0, 0, "R2 read uncached");
        do_op(1, 0, "R5 write by sole holder");
        do_op(0, 1, "R4 read of dirty");
        chk("R4 notice to writer only", int'(notice_vec), 4'b0001);
        do_op(1, 2, "R7 fetched write, all notified");
        chk("R7 go reply", int'(rep_kind), 1);
        do_op(0, 3, "R7 read in weak no notice");
        do_op(2, 0, "R9 drop");
        do_op(2, 1, "R9 drop");
        do_op(2, 2, "R9 drop");
        do_op(2, 3, "R9 drop to uncached");
        chk("R9 uncached", int'(blk_state), 0);

        // collection with two writers, foreign ack, eviction as ack
        do_op(0, 0, "R2 read");
        do_op(0, 1, "R2 read");
        do_op(0, 2, "R2 read");
        do_op(1, 0, "R6 write into weak");
        chk("R6 notices", int'(notice_vec), 4'b0110);
        chk("R6 wait", int'(rep_kind), 2);
        do_op(1, 1, "R7 second writer joins");
        chk("R7 no renotice", int'(notice_vec), 0);
        do_op(3, 3, "R8 foreign ack ignored");
        chk("R8 no release", int'(done_vec), 0);
        do_op(3, 1, "R8 ack");
        do_op(2, 2, "R9 eviction as ack");
        chk("R9 release both", int'(done_vec), 4'b0011);

        // leaving Weak and re-entering
        do_op(2, 1, "R10 back to dirty");
        chk("R10 dirty", int'(blk_state), 2);
        do_op(0, 1, "R10 weak again");
        chk("R10 fresh notice", int'(notice_vec), 4'b0001);
        do_op(2, 0, "R10 leave weak");
        do_op(2, 1, "R10 empty");
        do_op(0, 0, "R2 read");
        do_op(0, 1, "R2 read");
        do_op(1, 1, "R6 write");
        do_op(3, 0, "R8 last ack releases");
        chk("R8 release", int'(done_vec), 4'b0010);

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            int kind = int'($urandom % 4);
            int node = int'($urandom % N);
            if (kind == 3 && m_pd != '0 && ($urandom % 2) == 0)
                for (int i = 0; i < N; i++) if (m_pd[i]) node = i;
            do_op(kind, node, "R3 random");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule